// File: doc/BRIEF.md
# Two-Wire Serial Slave Front-End

This block is the bit-level front end of a slave on a two-wire clock-and-data bus. It oversamples the serial clock and data lines with a fast system clock, passes both through a synchronizer, and finds the serial clock edges and the bus framing events. A framing event is a data transition while the serial clock is high: falling data opens a transfer, and rising data closes one. Between these events it shifts in 8-bit words, most significant bit first. It checks the first word against its own address and acknowledges the words it accepts. When the master asks for a read, it drives the core's bytes onto a push-pull data output.

The core sees every accepted byte as a parallel value with a one-cycle valid strobe, plus one-cycle pulses for opening and closing conditions. It supplies the next read byte on `tx_byte`, which is sampled when `tx_next` pulses. It also raises `write_busy` while an internal write runs. While `write_busy` is high, or while the slave itself drives the data line, framing events are not recognised.

Top module: `tw_slave_fe`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe`, `rx_valid`, `start_pulse`, `stop_pulse` and `tx_next` are low.
- R2: A falling data line while the serial clock is high produces one single-cycle `start_pulse` and opens a new transfer from any state, unless detection is inhibited.
- R3: A rising data line while the serial clock is high produces one single-cycle `stop_pulse`. The slave returns to idle and does not acknowledge further bytes until a new start.
- R4: Bits are taken on serial clock rising edges, MSB first. In the first byte after a start, bits [7:1] are compared with `DEV_ADDR` and bit 0 selects the direction (1 = read, 0 = write). On a match the slave holds the data line low during the ninth clock. On a mismatch it never drives until the next start.
- R5: In write direction, the address byte and each following byte are acknowledged. Each accepted byte appears on `rx_byte` with a single-cycle `rx_valid`.
- R6: In read direction, `tx_byte` is captured at the falling edge that ends an acknowledge, with a `tx_next` pulse. It is then driven MSB first, with `sda_oe` high through the eight data clocks.
- R7: In read direction, a master acknowledge (data low on the ninth clock) makes the slave send the next byte. A not-acknowledge makes it release the line and drive nothing more until a new start.
- R8: `sda_oe`, and `sda_o` while driven, change only while the serial clock is low.
- R9: While `write_busy` is high, start and stop conditions produce no pulse and have no effect.
- R10: While the slave drives the data line, start and stop patterns produce no pulse, and the byte in flight continues.
- R11: A start in the middle of a write byte discards the partial bits, and the following byte is treated as a fresh address byte.
- R12: Before the first start condition, clocked bytes are neither acknowledged nor reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Serial data value driven by the slave |
| sda_oe | output | 1 | High while the slave drives the data line |
| rx_byte | output | DATA_W | Last accepted byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| start_pulse | output | 1 | One-cycle pulse on a recognised start |
| stop_pulse | output | 1 | One-cycle pulse on a recognised stop |
| tx_byte | input | DATA_W | Next read byte from the core |
| tx_next | output | 1 | One-cycle pulse when `tx_byte` is captured |
| write_busy | input | 1 | Core write in progress; masks framing events |

## Verification
The bench builds the block with an 8-bit word, a 7-bit address of 7'h55 (alternating bits, so single-bit address faults show) and a two-stage synchronizer. The small address lets every one of the 128 addresses be offered after a start, with exactly one acknowledged. The 8-bit word lets all 256 data values pass through one write transfer. Read bytes come from an arithmetic pattern indexed by the number of `tx_next` pulses, so each driven bit can be predicted. The bench also injects start and stop patterns into a driven bit and into a busy window, to show they are masked.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [2:0] {
        TW_IDLE,
        TW_RECV,
        TW_ACK_OUT,
        TW_SEND,
        TW_ACK_IN,
        TW_SKIP
    } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int                WIDTH     = 2,
    parameter int                STAGES    = 2,
    parameter logic [WIDTH-1:0]  RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;
        logic              prev_d, prev_q;

        always_comb begin
            chain_d = STAGES'({chain_q, async_i[g]});
            prev_d  = chain_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RESET_VAL[g]}};
                prev_q  <= RESET_VAL[g];
            end else begin
                chain_q <= chain_d;
                prev_q  <= prev_d;
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
        assign prev_o[g] = prev_q;
    end
endmodule

// File: rtl/tw_cond_det.sv
module tw_cond_det (
    input  logic scl_now,
    input  logic scl_was,
    input  logic sda_now,
    input  logic sda_was,
    input  logic inhibit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_now & scl_was;
        scl_rise      = scl_now & ~scl_was;
        scl_fall      = ~scl_now & scl_was;
        start_det     = scl_held_high & sda_was & ~sda_now & ~inhibit;
        stop_det      = scl_held_high & ~sda_was & sda_now & ~inhibit;
    end
endmodule

// File: rtl/tw_xfer_fsm.sv
module tw_xfer_fsm
    import tw_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-2:0] DEV_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              sda_o,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              tx_next
);
    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        tw_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              first;
        logic              rd;
        logic              mack;
        logic              oe;
        logic              o;
        logic [DATA_W-1:0] rx;
        logic              rxv;
        logic              sp;
        logic              pp;
        logic              txn;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        state: TW_IDLE, cnt: '0, sh: '0, first: 1'b0, rd: 1'b0, mack: 1'b0,
        oe: 1'b0, o: 1'b1, rx: '0, rxv: 1'b0, sp: 1'b0, pp: 1'b0, txn: 1'b0
    };

    fsm_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rxv = 1'b0;
        st_d.sp  = 1'b0;
        st_d.pp  = 1'b0;
        st_d.txn = 1'b0;

        if (start_det) begin
            st_d.state = TW_RECV;
            st_d.cnt   = '0;
            st_d.first = 1'b1;
            st_d.oe    = 1'b0;
            st_d.o     = 1'b1;
            st_d.sp    = 1'b1;
        end else if (stop_det) begin
            st_d.state = TW_IDLE;
            st_d.oe    = 1'b0;
            st_d.o     = 1'b1;
            st_d.pp    = 1'b1;
        end else begin
            unique case (st_q.state)
                TW_RECV: begin
                    if (scl_rise && st_q.cnt != CNT_FULL) begin
                        st_d.sh  = {st_q.sh[DATA_W-2:0], sda_bit};
                        st_d.cnt = st_q.cnt + CNT_ONE;
                    end else if (scl_fall && st_q.cnt == CNT_FULL) begin
                        if (st_q.first && st_q.sh[DATA_W-1:1] != DEV_ADDR) begin
                            st_d.state = TW_SKIP;
                        end else begin
                            st_d.state = TW_ACK_OUT;
                            st_d.oe    = 1'b1;
                            st_d.o     = 1'b0;
                            st_d.rxv   = 1'b1;
                            st_d.rx    = st_q.sh;
                            if (st_q.first) begin
                                st_d.rd = st_q.sh[0];
                            end
                        end
                    end
                end
                TW_ACK_OUT: begin
                    if (scl_fall) begin
                        st_d.first = 1'b0;
                        st_d.cnt   = '0;
                        if (st_q.rd) begin
                            st_d.state = TW_SEND;
                            st_d.sh    = tx_byte;
                            st_d.o     = tx_byte[DATA_W-1];
                            st_d.oe    = 1'b1;
                            st_d.txn   = 1'b1;
                        end else begin
                            st_d.state = TW_RECV;
                            st_d.oe    = 1'b0;
                            st_d.o     = 1'b1;
                        end
                    end
                end
                TW_SEND: begin
                    if (scl_rise) begin
                        st_d.cnt = st_q.cnt + CNT_ONE;
                    end else if (scl_fall) begin
                        if (st_q.cnt == CNT_FULL) begin
                            st_d.state = TW_ACK_IN;
                            st_d.oe    = 1'b0;
                            st_d.o     = 1'b1;
                        end else begin
                            st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
                            st_d.o  = st_q.sh[DATA_W-2];
                        end
                    end
                end
                TW_ACK_IN: begin
                    if (scl_rise) begin
                        st_d.mack = ~sda_bit;
                    end else if (scl_fall) begin
                        st_d.cnt = '0;
                        if (st_q.mack) begin
                            st_d.state = TW_SEND;
                            st_d.sh    = tx_byte;
                            st_d.o     = tx_byte[DATA_W-1];
                            st_d.oe    = 1'b1;
                            st_d.txn   = 1'b1;
                        end else begin
                            st_d.state = TW_SKIP;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FSM_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_o       = st_q.o;
    assign sda_oe      = st_q.oe;
    assign rx_byte     = st_q.rx;
    assign rx_valid    = st_q.rxv;
    assign start_pulse = st_q.sp;
    assign stop_pulse  = st_q.pp;
    assign tx_next     = st_q.txn;
endmodule

// File: rtl/tw_slave_fe.sv
module tw_slave_fe #(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-2:0] DEV_ADDR    = 7'h2B,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              start_pulse,
    output logic              stop_pulse,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_next,
    input  logic              write_busy
);
    localparam int LINES = 2;

    logic [LINES-1:0] line_now, line_was;
    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det, inhibit;

    tw_sync #(
        .WIDTH     (LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({LINES{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sda_i, scl_i}),
        .sync_o  (line_now),
        .prev_o  (line_was)
    );

    assign scl_s   = line_now[0];
    assign sda_s   = line_now[1];
    assign scl_p   = line_was[0];
    assign sda_p   = line_was[1];
    assign inhibit = sda_oe | write_busy;

    tw_cond_det u_cond (
        .scl_now   (scl_s),
        .scl_was   (scl_p),
        .sda_now   (sda_s),
        .sda_was   (sda_p),
        .inhibit   (inhibit),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_xfer_fsm #(
        .DATA_W   (DATA_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .sda_bit     (sda_s),
        .tx_byte     (tx_byte),
        .sda_o       (sda_o),
        .sda_oe      (sda_oe),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .tx_next     (tx_next)
    );
endmodule

// File: rtl/tw_slave_fe_chk.sv
module tw_slave_fe_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic write_busy,
    input logic sda_o,
    input logic sda_oe,
    input logic start_pulse,
    input logic stop_pulse,
    input logic rx_valid,
    input logic tx_next
);
    p_oe_edge_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    p_data_edge_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && $past(sda_oe) && !$stable(sda_o)) |-> !$past(scl_s));

    p_busy_mutes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(write_busy) |-> (!start_pulse && !stop_pulse));

    p_drive_mutes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sda_oe) |-> (!start_pulse && !stop_pulse));

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    p_stop_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !sda_oe);

    p_rx_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_load_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_next |-> sda_oe);
endmodule

bind tw_slave_fe tw_slave_fe_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .write_busy  (write_busy),
    .sda_o       (sda_o),
    .sda_oe      (sda_oe),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .rx_valid    (rx_valid),
    .tx_next     (tx_next)
);

// File: tb/tb_tw_slave_fe.sv
module tb_tw_slave_fe;
    localparam int         DW  = 8;
    localparam logic [6:0] DEV = 7'h55;
    localparam int         Q   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1, raw_mode = 1'b0, write_busy = 1'b0;
    logic sda_o, sda_oe, rx_valid, start_pulse, stop_pulse, tx_next;
    logic [DW-1:0] rx_byte, tx_byte;
    logic bus_sda;
    assign bus_sda = raw_mode ? m_sda : (sda_oe ? sda_o : m_sda);

    tw_slave_fe #(.DATA_W(DW), .DEV_ADDR(DEV), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_o(sda_o), .sda_oe(sda_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .tx_byte(tx_byte), .tx_next(tx_next), .write_busy(write_busy)
    );

    int n_chk = 0, n_bad = 0;
    int rx_n = 0, start_n = 0, stop_n = 0, tx_n = 0, r8_viol = 0;
    bit done = 1'b0;
    logic [DW-1:0] rx_log [0:511];
    logic prev_oe = 1'b0, prev_o = 1'b1;

    function automatic logic [DW-1:0] pat(int i);
        return DW'(i * 29 + 60);
    endfunction
    assign tx_byte = pat(tx_n);

    always begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            if (rx_valid) begin rx_log[rx_n] = rx_byte; rx_n++; end
            if (start_pulse) start_n++;
            if (stop_pulse) stop_n++;
            if (tx_next) tx_n++;
            if (m_scl && (sda_oe !== prev_oe || (sda_oe && prev_oe && sda_o !== prev_o)))
                r8_viol++;
        end
        prev_oe = sda_oe;
        prev_o  = sda_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        wait_clk(Q); m_sda = b;
        wait_clk(Q); m_scl = 1'b1;
        wait_clk(Q); s = bus_sda;
        wait_clk(Q); m_scl = 1'b0;
    endtask

    task automatic start_cond();
        wait_clk(Q); m_sda = 1'b1;
        wait_clk(Q); m_scl = 1'b1;
        wait_clk(Q); m_sda = 1'b0;
        wait_clk(Q); m_scl = 1'b0;
    endtask

    task automatic stop_cond();
        wait_clk(Q); m_sda = 1'b0;
        wait_clk(Q); m_scl = 1'b1;
        wait_clk(Q); m_sda = 1'b1;
        wait_clk(Q);
    endtask

    task automatic scl_low();
        wait_clk(Q); m_scl = 1'b0;
    endtask

    task automatic write_byte(input logic [DW-1:0] v, output logic ack);
        logic s;
        for (int i = DW - 1; i >= 0; i--) bit_xfer(v[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    // glitch_at < 0: plain byte; otherwise that bit carries a start and a stop pattern
    task automatic read_byte(input logic mack, input int glitch_at, output logic [DW-1:0] v);
        logic s;
        for (int i = DW - 1; i >= 0; i--) begin
            if (i == glitch_at) begin
                wait_clk(Q); raw_mode = 1'b1; m_sda = 1'b1;
                wait_clk(Q); m_scl = 1'b1;
                wait_clk(Q); m_sda = 1'b0;
                wait_clk(Q); m_sda = 1'b1;
                wait_clk(Q); m_scl = 1'b0;
                wait_clk(1); raw_mode = 1'b0;
                v[i] = 1'b0;
            end else begin
                bit_xfer(1'b1, s);
                v[i] = s;
            end
        end
        bit_xfer(~mack, s);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [DW-1:0] v;
        int rb, sb, pb, tb0;

        // R1: reset values
        wait_clk(3);
        chk("R1 oe in reset", sda_oe, 0);
        chk("R1 pulses in reset", {rx_valid, start_pulse, stop_pulse, tx_next}, 0);
        wait_clk(2); rst_n = 1'b1;
        wait_clk(4);
        chk("R1 oe after reset", sda_oe, 0);
        chk("R1 pulses after reset", {rx_valid, start_pulse, stop_pulse, tx_next}, 0);

        // R12: a matching address clocked before any start
        scl_low();
        write_byte({DEV, 1'b0}, ack);
        chk("R12 no ack before start", ack, 0);
        chk("R12 no byte before start", rx_n, 0);
        stop_cond();
        chk("R3 stop pulse counted", stop_n, 1);

        // R4 with R2/R3: sweep every address
        rb = rx_n; sb = start_n; pb = stop_n;
        for (int a = 0; a < 128; a++) begin
            start_cond();
            write_byte({7'(a), 1'b0}, ack);
            chk("R4 address ack", ack, (7'(a) == DEV));
            stop_cond();
        end
        chk("R2 start count", start_n - sb, 128);
        chk("R3 stop count", stop_n - pb, 128);
        chk("R4 one address byte reported", rx_n - rb, 1);
        chk("R4 reported address byte", rx_log[rb], {DEV, 1'b0});

        // R5: every data value through one write transfer
        rb = rx_n;
        start_cond();
        write_byte({DEV, 1'b0}, ack);
        chk("R5 address ack", ack, 1);
        for (int k = 0; k < 256; k++) begin
            write_byte(DW'(k), ack);
            chk("R5 data ack", ack, 1);
        end
        stop_cond();
        chk("R5 byte count", rx_n - rb, 257);
        for (int k = 0; k < 256; k++) chk("R5 data value", rx_log[rb + 1 + k], k);

        // R3: after stop, bytes without a start are ignored
        rb = rx_n;
        scl_low();
        write_byte({DEV, 1'b0}, ack);
        chk("R3 no ack after stop", ack, 0);
        chk("R3 no byte after stop", rx_n - rb, 0);
        stop_cond();

        // R6/R7: read 64 bytes, last one not acknowledged
        tb0 = tx_n;
        start_cond();
        write_byte({DEV, 1'b1}, ack);
        chk("R6 read address ack", ack, 1);
        for (int k = 0; k < 64; k++) begin
            read_byte(k != 63, -1, v);
            chk("R6 read data", v, pat(tb0 + k));
        end
        chk("R6 load count", tx_n - tb0, 64);
        read_byte(1'b1, -1, v);
        chk("R7 released after nack", v, 8'hFF);
        chk("R7 no drive after nack", sda_oe, 0);
        chk("R7 no further load", tx_n - tb0, 64);
        stop_cond();

        // R10: start and stop patterns inside a driven bit
        tb0 = tx_n; sb = start_n; pb = stop_n;
        start_cond();
        write_byte({DEV, 1'b1}, ack);
        chk("R10 read address ack", ack, 1);
        read_byte(1'b1, -1, v);
        chk("R10 first byte", v, pat(tb0));
        read_byte(1'b1, 3, v);
        chk("R10 byte continues", v & 8'hF7, pat(tb0 + 1) & 8'hF7);
        chk("R10 no start pulse", start_n - sb, 1);
        chk("R10 no stop pulse", stop_n - pb, 0);
        read_byte(1'b0, -1, v);
        chk("R10 following byte", v, pat(tb0 + 2));
        stop_cond();

        // R9: write_busy masks framing events
        write_busy = 1'b1;
        sb = start_n; pb = stop_n; rb = rx_n;
        start_cond();
        write_byte({DEV, 1'b0}, ack);
        chk("R9 no ack while busy", ack, 0);
        stop_cond();
        chk("R9 no start while busy", start_n - sb, 0);
        chk("R9 no stop while busy", stop_n - pb, 0);
        chk("R9 no byte while busy", rx_n - rb, 0);
        write_busy = 1'b0;
        wait_clk(Q);

        // R11: start in the middle of a data byte
        rb = rx_n; sb = start_n;
        start_cond();
        write_byte({DEV, 1'b0}, ack);
        chk("R11 first address ack", ack, 1);
        bit_xfer(1'b1, ack);
        bit_xfer(1'b0, ack);
        bit_xfer(1'b1, ack);
        start_cond();
        write_byte({DEV, 1'b0}, ack);
        chk("R11 fresh address ack", ack, 1);
        write_byte(8'hC3, ack);
        chk("R11 data ack", ack, 1);
        stop_cond();
        chk("R11 start count", start_n - sb, 2);
        chk("R11 byte count", rx_n - rb, 3);
        chk("R11 second byte is address", rx_log[rb + 1], {DEV, 1'b0});
        chk("R11 data byte", rx_log[rb + 2], 8'hC3);

        // R8: output changes only with the serial clock low
        chk("R8 edges while clock high", r8_viol, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule